// File: doc/BRIEF.md
# DMA Channel Control and Status Register File

This block is the software-visible register file of a sixteen-channel DMA controller. It takes 32-bit word accesses through two address windows. The main window is 4 KB. Offsets below 0xF00 in it select one of channels 0 to 14, and two global registers sit near its top. The second window is 256 bytes and serves channel 15 alone, with the same per-channel layout. Each channel holds a control/status word, a control-block pointer, a free debug word, and six read-only copies of the control block that the transfer engine is running. The engine loads those copies through a dedicated port.

The control/status word mixes three write behaviours. Status flags are cleared by writing 1 to them. A self-clearing channel reset bit wipes the word and the pointer. A masked field is overwritten from the written data. When a write moves the active bit from 0 to 1, the block sends a one-cycle start pulse to the engine, together with the channel's control-block pointer. The engine reports back in three ways: the end of a control block, with or without an interrupt, and the halt of a channel. The interrupt-status register drives one IRQ line per channel.

Top module: `dma_chan_regfile`

## Requirements
- R1: After reset the global enable reads 0xFFFF, the global interrupt status reads 0, every channel's control/status word and control-block pointer read 0, and all IRQ and start outputs are low.
- R2: In the main window, address bits [11:8] select the channel when the address is below 0xF00, and bits [7:0] select the register. The second window always addresses channel 15 through the same register layout. Channels do not alias each other.
- R3: The control-block pointer (offset 0x04) and the debug word (offset 0x20) are read/write. Offsets 0x08, 0x0C, 0x10, 0x14, 0x18 and 0x1C return the info, source, destination, length, stride and next-pointer values last loaded by the engine for that channel. A write to any of these six offsets changes nothing.
- R4: The global enable at 0xFF0 keeps only the low 16 bits of a write. The global interrupt status at 0xFE0 is read-only, and a write to it is accepted without effect.
- R5: Writing 1 to control/status bit 31 clears that channel's control/status word and control-block pointer. The global interrupt-status bit and the IRQ line of that channel keep their values.
- R6: Writing 1 to control/status bit 1 clears the end flag. Writing 1 to bit 2 clears the interrupt flag, the channel's global interrupt-status bit, and its IRQ line.
- R7: After the clear handling, control/status bits under mask 0x30FF0001 (bit 0, bits 23:16, bits 29:28) take the written value. All other bits keep their old values, including paused (bit 4), held (bit 5) and error (bit 8). Bits 30 and 31 always read 0, and writing bit 30 has no effect.
- R8: A one-cycle start pulse on the channel's start bit, with the control-block pointer on the start address output, follows a control/status write only when active (bit 0) was 0 before the write and is 1 after it.
- R9: A block-done event sets the end flag and loads the control-block pointer from the loaded next-pointer copy. If the event carries an interrupt, it also sets control/status bit 2, the global status bit and the IRQ line.
- R10: A halt event clears active and sets paused (bit 4). A bus write to the same control/status word in the same cycle is applied before the halt.
- R11: Accesses to undefined offsets, unaligned offsets, or writes to read-only channel registers read as 0 and change nothing. Each raises a one-cycle error pulse in the cycle after the access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_hi | input | 1 | 1 = channel-15 window, 0 = main window |
| req_addr | input | 12 | Byte offset within the window |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Read data, same cycle as request |
| bad_access | output | 1 | One-cycle pulse after an illegal access |
| start | output | 16 | Per-channel start pulse to the engine |
| start_cb | output | 32 | Control-block pointer sent with the last start |
| chan_en | output | 16 | Global channel-enable mask |
| irq | output | 16 | Per-channel interrupt lines |
| ld_valid | input | 1 | Engine loads a control-block copy |
| ld_ch | input | 4 | Channel of the load |
| ld_info | input | 32 | Transfer info copy |
| ld_src | input | 32 | Source address copy |
| ld_dst | input | 32 | Destination address copy |
| ld_len | input | 32 | Transfer length copy |
| ld_stride | input | 32 | Stride copy |
| ld_next | input | 32 | Next control-block pointer copy |
| done_cb | input | 16 | Per-channel block-done event |
| done_irq | input | 16 | Block-done event requests an interrupt |
| halt | input | 16 | Per-channel halt event |

## Verification
The hardest states to reach from the ports are the collisions between a bus write and an engine event in the same cycle. The bench creates them by driving a halt on the same clock edge as a control/status write that raises active. It then checks that the start pulse still fires while the word settles paused and inactive. It also re-raises an interrupt through a block-done event and then resets the channel, to show that the global status bit outlives the channel reset. A combined write of all ones tests the order reset, clear, then mask, and checks the start it produces with a zero pointer.

// File: rtl/dma_chan_regfile.sv
module dma_chan_regfile #(
  parameter int          NCH     = 16,
  parameter logic [31:0] RW_MASK = 32'h30FF_0001
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  input  logic                     req_write,
  input  logic                     req_hi,
  input  logic [11:0]              req_addr,
  input  logic [31:0]              req_wdata,
  output logic [31:0]              rsp_rdata,
  output logic                     bad_access,
  output logic [NCH-1:0]           start,
  output logic [31:0]              start_cb,
  output logic [NCH-1:0]           chan_en,
  output logic [NCH-1:0]           irq,
  input  logic                     ld_valid,
  input  logic [$clog2(NCH)-1:0]   ld_ch,
  input  logic [31:0]              ld_info,
  input  logic [31:0]              ld_src,
  input  logic [31:0]              ld_dst,
  input  logic [31:0]              ld_len,
  input  logic [31:0]              ld_stride,
  input  logic [31:0]              ld_next,
  input  logic [NCH-1:0]           done_cb,
  input  logic [NCH-1:0]           done_irq,
  input  logic [NCH-1:0]           halt
);

  localparam int          CW       = $clog2(NCH);
  localparam int          TOP      = NCH - 1;
  localparam logic [11:0] CHAN_LIM = 12'hF00;
  localparam logic [11:0] ST_OFF   = 12'hFE0;
  localparam logic [11:0] EN_OFF   = 12'hFF0;

  logic [31:0] cs_q [NCH];
  logic [31:0] cb_q [NCH];
  logic [31:0] dbg_q [NCH];
  logic [31:0] info_q [NCH];
  logic [31:0] src_q [NCH];
  logic [31:0] dst_q [NCH];
  logic [31:0] len_q [NCH];
  logic [31:0] str_q [NCH];
  logic [31:0] nxt_q [NCH];
  logic [NCH-1:0] en_q, st_q;

  logic [31:0] cs_n [NCH];
  logic [31:0] cb_n [NCH];
  logic [NCH-1:0] st_n, start_n;

  logic [CW-1:0] ch;
  logic [7:0]    off;
  logic          in_chan, at_st, at_en, off_ok, ro_off, bad_now, do_wr;

  assign ch      = req_hi ? CW'(TOP) : req_addr[8 +: CW];
  assign off     = req_addr[7:0];
  assign in_chan = req_hi || (req_addr < CHAN_LIM);
  assign at_st   = !req_hi && (req_addr == ST_OFF);
  assign at_en   = !req_hi && (req_addr == EN_OFF);
  assign off_ok  = (off[1:0] == 2'b00) && (off <= 8'h20);
  assign ro_off  = (off >= 8'h08) && (off <= 8'h1C);
  assign bad_now = req_valid && (in_chan ? (!off_ok || (req_write && ro_off))
                                         : !(at_st || at_en));
  assign do_wr   = req_valid && req_write && !bad_now;

  assign chan_en = en_q;
  assign irq     = st_q;

  always_comb begin
    rsp_rdata = '0;
    if (req_valid && !req_write && !bad_now) begin
      if (in_chan) begin
        case (off)
          8'h00:   rsp_rdata = cs_q[ch];
          8'h04:   rsp_rdata = cb_q[ch];
          8'h08:   rsp_rdata = info_q[ch];
          8'h0C:   rsp_rdata = src_q[ch];
          8'h10:   rsp_rdata = dst_q[ch];
          8'h14:   rsp_rdata = len_q[ch];
          8'h18:   rsp_rdata = str_q[ch];
          8'h1C:   rsp_rdata = nxt_q[ch];
          8'h20:   rsp_rdata = dbg_q[ch];
          default: rsp_rdata = '0;
        endcase
      end else if (at_st) begin
        rsp_rdata = 32'(st_q);
      end else begin
        rsp_rdata = 32'(en_q);
      end
    end
  end

  logic [31:0] t;
  logic        hit;

  always_comb begin
    t   = '0;
    hit = 1'b0;
    for (int c = 0; c < NCH; c++) begin
      hit        = do_wr && in_chan && (ch == CW'(c));
      t          = cs_q[c];
      cb_n[c]    = cb_q[c];
      st_n[c]    = st_q[c];
      start_n[c] = 1'b0;
      if (hit && off == 8'h00) begin
        if (req_wdata[31]) begin
          t       = '0;
          cb_n[c] = '0;
        end
        if (req_wdata[1]) t[1] = 1'b0;
        if (req_wdata[2]) begin
          t[2]    = 1'b0;
          st_n[c] = 1'b0;
        end
        t          = (t & ~RW_MASK) | (req_wdata & RW_MASK);
        start_n[c] = !cs_q[c][0] && t[0];
      end
      if (hit && off == 8'h04) cb_n[c] = req_wdata;
      if (done_cb[c]) begin
        t[1]    = 1'b1;
        cb_n[c] = nxt_q[c];
        if (done_irq[c]) begin
          t[2]    = 1'b1;
          st_n[c] = 1'b1;
        end
      end
      if (halt[c]) begin
        t[0] = 1'b0;
        t[4] = 1'b1;
      end
      cs_n[c] = t;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q       <= '1;
      st_q       <= '0;
      start      <= '0;
      start_cb   <= '0;
      bad_access <= 1'b0;
      for (int c = 0; c < NCH; c++) begin
        cs_q[c]   <= '0;
        cb_q[c]   <= '0;
        dbg_q[c]  <= '0;
        info_q[c] <= '0;
        src_q[c]  <= '0;
        dst_q[c]  <= '0;
        len_q[c]  <= '0;
        str_q[c]  <= '0;
        nxt_q[c]  <= '0;
      end
    end else begin
      bad_access <= bad_now;
      start      <= start_n;
      st_q       <= st_n;
      if (do_wr && at_en) en_q <= req_wdata[NCH-1:0];
      for (int c = 0; c < NCH; c++) begin
        cs_q[c] <= cs_n[c];
        cb_q[c] <= cb_n[c];
        if (start_n[c]) start_cb <= cb_n[c];
      end
      if (do_wr && in_chan && off == 8'h20) dbg_q[ch] <= req_wdata;
      if (ld_valid) begin
        info_q[ld_ch] <= ld_info;
        src_q[ld_ch]  <= ld_src;
        dst_q[ld_ch]  <= ld_dst;
        len_q[ld_ch]  <= ld_len;
        str_q[ld_ch]  <= ld_stride;
        nxt_q[ld_ch]  <= ld_next;
      end
    end
  end

  a_r8_start_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(start));

  a_r11_bad_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
    bad_access |-> $past(req_valid));

  for (genvar g = 0; g < NCH; g++) begin : g_chk
    a_r10_halt_pauses: assert property (@(posedge clk) disable iff (!rst_n)
      halt[g] |=> (!cs_q[g][0] && cs_q[g][4]));

    a_r9_irq_raised: assert property (@(posedge clk) disable iff (!rst_n)
      (done_cb[g] && done_irq[g]) |=> irq[g]);

    a_r7_wo_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
      cs_q[g][31:30] == 2'b00);

    a_r8_start_sets_active: assert property (@(posedge clk) disable iff (!rst_n)
      (start[g] && !$past(halt[g])) |-> cs_q[g][0]);
  end

endmodule

// File: tb/dma_chan_regfile_tb.sv
module dma_chan_regfile_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write, req_hi;
  logic [11:0] req_addr;
  logic [31:0] req_wdata;
  logic [31:0] rsp_rdata;
  logic        bad_access;
  logic [15:0] start, chan_en, irq;
  logic [31:0] start_cb;
  logic        ld_valid;
  logic [3:0]  ld_ch;
  logic [31:0] ld_info, ld_src, ld_dst, ld_len, ld_stride, ld_next;
  logic [15:0] done_cb, done_irq, halt;

  int total = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  dma_chan_regfile u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write), .req_hi(req_hi),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_rdata(rsp_rdata),
    .bad_access(bad_access), .start(start), .start_cb(start_cb),
    .chan_en(chan_en), .irq(irq),
    .ld_valid(ld_valid), .ld_ch(ld_ch), .ld_info(ld_info), .ld_src(ld_src),
    .ld_dst(ld_dst), .ld_len(ld_len), .ld_stride(ld_stride), .ld_next(ld_next),
    .done_cb(done_cb), .done_irq(done_irq), .halt(halt)
  );

  // {write, hi window, pad, addr, wdata, expected read}
  localparam int NV = 16;
  localparam logic [79:0] VEC [NV] = '{
    {1'b1, 1'b0, 2'b0, 12'h004, 32'h0000_1000, 32'h0},           // R3
    {1'b0, 1'b0, 2'b0, 12'h004, 32'h0,         32'h0000_1000},   // R3
    {1'b1, 1'b0, 2'b0, 12'h104, 32'h0000_1100, 32'h0},           // R2
    {1'b1, 1'b0, 2'b0, 12'h304, 32'h0000_3300, 32'h0},           // R2
    {1'b0, 1'b0, 2'b0, 12'h304, 32'h0,         32'h0000_3300},   // R2
    {1'b0, 1'b0, 2'b0, 12'h204, 32'h0,         32'h0},           // R2
    {1'b1, 1'b1, 2'b0, 12'h004, 32'h0000_F0F0, 32'h0},           // R2
    {1'b0, 1'b1, 2'b0, 12'h004, 32'h0,         32'h0000_F0F0},   // R2
    {1'b0, 1'b0, 2'b0, 12'hE04, 32'h0,         32'h0},           // R2
    {1'b1, 1'b0, 2'b0, 12'h020, 32'hDEAD_BEEF, 32'h0},           // R3
    {1'b0, 1'b0, 2'b0, 12'h020, 32'h0,         32'hDEAD_BEEF},   // R3
    {1'b0, 1'b0, 2'b0, 12'h120, 32'h0,         32'h0},           // R3
    {1'b1, 1'b0, 2'b0, 12'hFF0, 32'hABCD_1234, 32'h0},           // R4
    {1'b0, 1'b0, 2'b0, 12'hFF0, 32'h0,         32'h0000_1234},   // R4
    {1'b1, 1'b0, 2'b0, 12'hFE0, 32'hFFFF_FFFF, 32'h0},           // R4
    {1'b0, 1'b0, 2'b0, 12'hFE0, 32'h0,         32'h0}            // R4
  };
  localparam int VREQ [NV] = '{3,3,2,2,2,2,2,2,2,3,3,3,4,4,4,4};

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic hi, input logic [11:0] a, input logic [31:0] d);
    req_valid = 1'b1; req_write = 1'b1; req_hi = hi; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd(input logic hi, input logic [11:0] a, output logic [31:0] d);
    req_valid = 1'b1; req_write = 1'b0; req_hi = hi; req_addr = a; req_wdata = '0;
    #1 d = rsp_rdata;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic ev(input logic [15:0] dn, input logic [15:0] iq, input logic [15:0] hl);
    done_cb = dn; done_irq = iq; halt = hl;
    @(negedge clk);
    done_cb = '0; done_irq = '0; halt = '0;
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", total - fails, total);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_hi = 1'b0;
    req_addr = '0; req_wdata = '0; ld_valid = 1'b0; ld_ch = '0;
    ld_info = '0; ld_src = '0; ld_dst = '0; ld_len = '0; ld_stride = '0; ld_next = '0;
    done_cb = '0; done_irq = '0; halt = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(1'b0, 12'hFF0, d); chk("R1 enable", d, 32'h0000_FFFF);
    rd(1'b0, 12'hFE0, d); chk("R1 int status", d, 32'h0);
    rd(1'b0, 12'h500, d); chk("R1 cs ch5", d, 32'h0);
    rd(1'b0, 12'h504, d); chk("R1 cb ch5", d, 32'h0);
    chk("R1 irq", 32'(irq), 32'h0);
    chk("R1 start", 32'(start), 32'h0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][79]) begin
        wr(VEC[i][78], VEC[i][75:64], VEC[i][63:32]);
        chk($sformatf("R%0d vec%0d no error", VREQ[i], i), 32'(bad_access), 32'h0);
      end else begin
        rd(VEC[i][78], VEC[i][75:64], d);
        chk($sformatf("R%0d vec%0d read", VREQ[i], i), d, VEC[i][31:0]);
      end
    end
    wr(1'b0, 12'hFF0, 32'h0000_FFFF);
    chk("R4 chan_en port", 32'(chan_en), 32'h0000_FFFF);

    // R7 masked field, write-only and non-writable bits
    wr(1'b0, 12'h100, 32'h40A5_0130);
    chk("R7 no start", 32'(start), 32'h0);
    rd(1'b0, 12'h100, d); chk("R7 masked cs", d, 32'h00A5_0000);

    // R8 start on rising active
    wr(1'b0, 12'h100, 32'h00A5_0001);
    chk("R8 start pulse", 32'(start), 32'h0000_0002);
    chk("R8 start addr", start_cb, 32'h0000_1100);
    @(negedge clk);
    chk("R8 pulse one cycle", 32'(start), 32'h0);
    wr(1'b0, 12'h100, 32'h00A5_0001);
    chk("R8 no start when already active", 32'(start), 32'h0);

    // R10 halt
    ev(16'h0, 16'h0, 16'h0002);
    rd(1'b0, 12'h100, d); chk("R10 halted cs", d, 32'h00A5_0010);
    halt = 16'h0002;
    wr(1'b0, 12'h100, 32'h0000_0001);
    halt = 16'h0;
    chk("R10 start from concurrent write", 32'(start), 32'h0000_0002);
    rd(1'b0, 12'h100, d); chk("R10 halt after write", d, 32'h0000_0010);

    // R3 control-block copies
    ld_valid = 1'b1; ld_ch = 4'd1; ld_info = 32'h11; ld_src = 32'h22; ld_dst = 32'h33;
    ld_len = 32'h44; ld_stride = 32'h55; ld_next = 32'h2000;
    @(negedge clk);
    ld_valid = 1'b0;
    rd(1'b0, 12'h108, d); chk("R3 info", d, 32'h11);
    rd(1'b0, 12'h10C, d); chk("R3 src", d, 32'h22);
    rd(1'b0, 12'h110, d); chk("R3 dst", d, 32'h33);
    rd(1'b0, 12'h114, d); chk("R3 len", d, 32'h44);
    rd(1'b0, 12'h118, d); chk("R3 stride", d, 32'h55);
    rd(1'b0, 12'h11C, d); chk("R3 next", d, 32'h2000);
    wr(1'b0, 12'h108, 32'hFFFF);
    chk("R11 write ro error", 32'(bad_access), 32'h1);
    rd(1'b0, 12'h108, d); chk("R3 ro unchanged", d, 32'h11);

    // R9 block done
    ev(16'h0002, 16'h0002, 16'h0);
    chk("R9 irq", 32'(irq), 32'h0000_0002);
    rd(1'b0, 12'h100, d); chk("R9 cs end+int", d, 32'h0000_0016);
    rd(1'b0, 12'h104, d); chk("R9 cb from next", d, 32'h2000);
    rd(1'b0, 12'hFE0, d); chk("R9 global status", d, 32'h2);
    ev(16'h0008, 16'h0, 16'h0);
    rd(1'b0, 12'h300, d); chk("R9 end only", d, 32'h0000_0002);
    chk("R9 no irq ch3", 32'(irq), 32'h0000_0002);

    // R6 write-1-to-clear
    wr(1'b0, 12'h100, 32'h0000_0002);
    rd(1'b0, 12'h100, d); chk("R6 end cleared", d, 32'h0000_0014);
    chk("R6 irq kept", 32'(irq), 32'h0000_0002);
    wr(1'b0, 12'h100, 32'h0000_0004);
    rd(1'b0, 12'h100, d); chk("R6 int cleared", d, 32'h0000_0010);
    chk("R6 irq dropped", 32'(irq), 32'h0);
    rd(1'b0, 12'hFE0, d); chk("R6 status cleared", d, 32'h0);

    // R5 channel reset
    ev(16'h0002, 16'h0002, 16'h0);
    wr(1'b0, 12'h100, 32'h8000_0000);
    rd(1'b0, 12'h100, d); chk("R5 cs cleared", d, 32'h0);
    rd(1'b0, 12'h104, d); chk("R5 cb cleared", d, 32'h0);
    rd(1'b0, 12'hFE0, d); chk("R5 status kept", d, 32'h2);
    chk("R5 irq kept", 32'(irq), 32'h0000_0002);
    wr(1'b0, 12'h104, 32'h0000_7700);
    wr(1'b0, 12'h100, 32'hFFFF_FFFF);
    chk("R5 reset then start", 32'(start), 32'h0000_0002);
    chk("R5 start addr zero", start_cb, 32'h0);
    rd(1'b0, 12'h100, d); chk("R7 all ones", d, 32'h30FF_0001);

    // R11 illegal accesses
    rd(1'b0, 12'h024, d); chk("R11 undefined reads 0", d, 32'h0);
    chk("R11 error pulse", 32'(bad_access), 32'h1);
    @(negedge clk);
    chk("R11 pulse one cycle", 32'(bad_access), 32'h0);
    rd(1'b0, 12'hF40, d); chk("R11 global hole", d, 32'h0);
    chk("R11 global hole error", 32'(bad_access), 32'h1);
    rd(1'b0, 12'h102, d); chk("R11 unaligned", d, 32'h0);
    chk("R11 unaligned error", 32'(bad_access), 32'h1);
    wr(1'b0, 12'hF44, 32'h1);
    chk("R11 hole write error", 32'(bad_access), 32'h1);
    rd(1'b0, 12'hFF0, d); chk("R11 enable untouched", d, 32'h0000_FFFF);
    chk("R11 legal read no error", 32'(bad_access), 32'h0);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule